// File: doc/BRIEF.md
# Registered Parallel-Prefix Adder

This block adds two unsigned operands and a one-bit carry-in. The operands and the carry-in are first captured in an input register. The sum and carry-out are then computed combinationally with a logarithmic-depth parallel-prefix carry network. The result is captured in an output register on the following clock edge. The block is intended as a single timed stage between two register banks, and it produces one new result every clock cycle.

Inside, each bit position first forms a generate term and a propagate term. The carry-in is placed as an extra lowest column whose generate is the carry-in and whose propagate is zero, so every prefix span ends at that column. A divide-and-conquer prefix tree then merges spans of width 2, 4, 8 and 16. Each level doubles the block size, and the top column of each lower half fans out to every column of the upper half. Each sum bit is the operand bit XOR combined with the group generate of all bits below it. The block has no state machine. It has two register banks and no control states or transitions.

Top module: `pfx_add_reg`

## Requirements
- R1: Operands presented at the ports before clock edge N appear as sum_o = (a_i + b_i + cin_i) mod 2^WIDTH after clock edge N+1. The input register loads at edge N and the output register loads at edge N+1.
- R2: cout_o is bit WIDTH of the full-width sum a_i + b_i + cin_i, with the same timing as sum_o.
- R3: A carry-in of 1 with a_i all ones and b_i zero ripples through every prefix span, giving sum_o = 0 and cout_o = 1.
- R4: When rst_i is high at a clock edge, both the input register and the output register clear to zero. sum_o and cout_o are 0 after that edge, and they are still 0 after the first edge with rst_i low.
- R5: Zero operands with carry-in 0 give sum_o = 0 and cout_o = 0.
- R6: The carry-in adds exactly one to the result. The results for cin_i = 1 and cin_i = 0 on the same operands differ by one modulo 2^(WIDTH+1).
- R7: A carry generated at the top bit alone (a_i = b_i = 0x8000) gives sum_o = 0 and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all registers load on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset for both register banks |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out |

## Verification
A wrong prefix cell or a wrong fan-out source corrupts only the sum bits whose span passes through that cell. The error shows at sum_o exactly one edge after the input register loads the triggering operands. Vectors that drive long carry chains are needed to expose cells high in the tree, because short chains never route a carry through them. A faulty reset or a lost register shows as a one-cycle shift or as a nonzero output right after reset. The scoreboard's fixed two-edge alignment exposes either fault on the first affected vector.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Prefix merge: high span over low span
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/pfx_bit_gp.sv
module pfx_bit_gp #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign g_o[i] = a_i[i] & b_i[i];
            assign p_o[i] = a_i[i] ^ b_i[i];
        end
    endgenerate
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree #(
    parameter int WIDTH = 16
) (
    input  logic             cin_i,
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    // column k holds the group generate from bit k-1 down to the carry-in
    output logic [WIDTH-1:0] grp_g_o
);
    import pfx_pkg::*;

    localparam int LEVELS = $clog2(WIDTH);

    gp_t col [LEVELS+1][WIDTH];

    genvar l, k;
    generate
        // level 0: column 0 is the carry-in, column k is bit k-1
        for (k = 0; k < WIDTH; k++) begin : g_seed
            if (k == 0) begin : g_cin
                assign col[0][k].g = cin_i;
                assign col[0][k].p = 1'b0;
            end else begin : g_bit
                assign col[0][k].g = g_i[k-1];
                assign col[0][k].p = p_i[k-1];
            end
        end

        for (l = 0; l < LEVELS; l++) begin : g_lvl
            for (k = 0; k < WIDTH; k++) begin : g_col
                if (((k >> l) & 1) == 1) begin : g_cell
                    localparam int SRC = ((k >> l) << l) - 1;
                    assign col[l+1][k] = gp_merge(col[l][k], col[l][SRC]);
                end else begin : g_pass
                    assign col[l+1][k] = col[l][k];
                end
            end
        end

        for (k = 0; k < WIDTH; k++) begin : g_out
            assign grp_g_o[k] = col[LEVELS][k].g;
        end
    endgenerate
endmodule

// File: rtl/pfx_sum.sv
module pfx_sum #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    input  logic [WIDTH-1:0] grp_g_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    assign sum_o  = p_i ^ grp_g_i;
    assign cout_o = g_i[WIDTH-1] | (p_i[WIDTH-1] & grp_g_i[WIDTH-1]);
endmodule

// File: rtl/pfx_add_reg.sv
module pfx_add_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH-1:0] a_q, b_q;
    logic             cin_q;
    logic [WIDTH-1:0] g_w, p_w, grp_w, sum_w;
    logic             cout_w;

    // launch register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
        end else begin
            a_q   <= a_i;
            b_q   <= b_i;
            cin_q <= cin_i;
        end
    end

    pfx_bit_gp #(.WIDTH(WIDTH)) gp_i (
        .a_i(a_q), .b_i(b_q), .g_o(g_w), .p_o(p_w)
    );

    pfx_tree #(.WIDTH(WIDTH)) tree_i (
        .cin_i(cin_q), .g_i(g_w), .p_i(p_w), .grp_g_o(grp_w)
    );

    pfx_sum #(.WIDTH(WIDTH)) sum_i (
        .g_i(g_w), .p_i(p_w), .grp_g_i(grp_w), .sum_o(sum_w), .cout_o(cout_w)
    );

    // capture register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sum_o  <= '0;
            cout_o <= 1'b0;
        end else begin
            sum_o  <= sum_w;
            cout_o <= cout_w;
        end
    end

    // arithmetic reference for the checks
    logic [WIDTH:0] ref_w;
    assign ref_w = {1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, cin_q};

    a_r1_sum_one_clock: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> sum_o == $past(ref_w[WIDTH-1:0]));

    a_r2_cout_top_bit: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> cout_o == $past(ref_w[WIDTH]));

    a_r4_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (sum_o == '0 && !cout_o));

    a_r5_zero_in_zero_out: assert property (@(posedge clk_i) disable iff (rst_i)
        (a_q == '0 && b_q == '0 && !cin_q) |=> (sum_o == '0 && !cout_o));
endmodule

// File: tb/pfx_add_reg_tb_top.sv
module pfx_add_reg_tb_top;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] sum;
        logic         cout;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    pfx_add_reg #(.WIDTH(W)) dut_i (
        .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout)
    );

    task automatic check(input string req, input logic [W-1:0] s_exp, input logic c_exp);
        checks++;
        if (sum !== s_exp || cout !== c_exp) begin
            fails++;
            $display("FAIL %s: got sum=%h cout=%b expected sum=%h cout=%b",
                     req, sum, cout, s_exp, c_exp);
        end
    endtask

    // driver: apply at negedge, push the expected result
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string req);
        logic [W:0] t;
        exp_t e;
        @(negedge clk);
        a = x; b = y; cin = c;
        t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        e.sum = t[W-1:0]; e.cout = t[W]; e.req = req;
        q.push_back(e);
    endtask

    // monitor: result for the vector driven at negedge k is visible after posedge k+2
    always @(posedge clk) begin
        #1;
        if (!rst && q.size() >= 2) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, e.sum, e.cout);
        end
    end

    initial begin
        // reset state (R4)
        repeat (3) @(negedge clk);
        check("R4", '0, 1'b0);
        rst = 1'b0;

        drive(16'h0000, 16'h0000, 1'b0, "R5");
        drive(16'hFFFF, 16'h0000, 1'b1, "R3");
        drive(16'h8000, 16'h8000, 1'b0, "R7");
        drive(16'h1234, 16'h4321, 1'b0, "R1");
        drive(16'h1234, 16'h4321, 1'b1, "R6");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R2");
        drive(16'hFFFF, 16'hFFFF, 1'b0, "R6");
        drive(16'h7FFF, 16'h0001, 1'b0, "R1");
        drive(16'h00FF, 16'h0000, 1'b1, "R3");
        drive(16'hAAAA, 16'h5555, 1'b1, "R2");
        for (int i = 0; i < 400; i++)
            drive(W'($urandom), W'($urandom), 1'($urandom), "R1");
        drive('0, '0, 1'b0, "R5");
        drive('0, '0, 1'b0, "R5");
        repeat (3) @(negedge clk);
        q.delete();

        // synchronous reset with nonzero inputs (R4)
        a = 16'hFFFF; b = 16'h0001; cin = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R4", '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R4", '0, 1'b0);
        @(negedge clk);
        check("R1", 16'h0001, 1'b1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule